// File: doc/BRIEF.md
# Authorized Load and Refresh Copy Gate

This block decides whether a scratchpad copy requested by the load-secret command (code 5Ah) may go ahead, and then starts it. The byte layer of the serial interface gives it the command bytes, the target addresses of scratchpad writes and refreshes, and the three authorization bytes that follow a 5Ah. The block keeps the target address register, the authorization-accepted flag and a refresh-permission flag. It compares the authorization bytes with its own registers and checks the protection inputs. It then either pulses a copy start toward the memory and holds busy for a fixed programming interval, or rejects the request at once.

The 5Ah command has two meanings. With the refresh-permission flag clear, it installs a new secret at address 0080h. With the flag set by a refresh to a data address, it writes the scratchpad back into data memory and needs no MAC. Any command that could change the scratchpad or the target address withdraws that permission. The answer byte is AAh after a completed copy and FFh after a rejection.

Top module: `lfs_copy_gate`

## Requirements
- R1: After a 5Ah command the block takes three authorization bytes in this order: the low target byte with bits 2..0 zero, the high target byte, then the status byte. The status byte has bit 7 = AA flag, bit 6 = 1, bit 5 = pf_flag and bits 4..0 = 1. Any mismatch gives no copy and a FFh answer.
- R2: With en_lfs at 0, a matching pattern copies into the secret (copy_to_secret = 1) only when target_addr is 0080h and secret_wp is 0. On that copy aa_flag is set.
- R3: With en_lfs at 1, a matching pattern copies into data memory (copy_to_secret = 0) only when target_addr is below 0080h, mem_wp is 0, and page0_wp is 0 or the target is 0020h or above.
- R4: A refresh (command A3h) whose address is below 0080h sets en_lfs. A refresh to 0080h..008Fh leaves en_lfs at 0.
- R5: A command byte other than AAh (read scratchpad), F0h (read memory) or 5Ah clears en_lfs when it is received. The three listed codes leave en_lfs unchanged.
- R6: An address that follows a write (0Fh) or refresh (A3h) command and is below 0090h loads target_addr with bits 2..0 forced to zero and clears aa_flag. An address of 0090h or above changes neither target_addr nor aa_flag.
- R7: An accepted copy raises copy_start for exactly one cycle and busy for PROG_CYCLES cycles, starting in the same cycle. In the cycle after busy ends, resp_stb pulses with resp_byte AAh.
- R8: A rejected request, by pattern or by protection, pulses resp_stb with resp_byte FFh in the cycle after the third authorization byte, and raises neither copy_start nor busy.
- R9: bus_reset during the authorization bytes aborts the command and leaves aa_flag and en_lfs unchanged. Authorization bytes that arrive afterwards are ignored until the next 5Ah.
- R10: After rst_n the block is idle with aa_flag, en_lfs, busy, copy_start and resp_stb at 0 and target_addr at 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | Reset pulse seen on the serial bus |
| cmd_stb | input | 1 | A command byte has been received |
| cmd_byte | input | 8 | Command code |
| addr_stb | input | 1 | A two-byte target address has been received |
| addr_in | input | 16 | Target address as sent by the master |
| auth_stb | input | 1 | An authorization byte has been received |
| auth_byte | input | 8 | Authorization byte |
| pf_flag | input | 1 | Partial-byte flag kept by the byte layer |
| secret_wp | input | 1 | Secret is write-protected |
| mem_wp | input | 1 | All data pages are write-protected |
| page0_wp | input | 1 | Data page 0 (0000h..001Fh) is write-protected |
| copy_start | output | 1 | One-cycle request to start programming |
| copy_to_secret | output | 1 | Destination of the copy: 1 secret, 0 data memory |
| busy | output | 1 | Programming interval in progress |
| resp_stb | output | 1 | Answer byte is valid for this cycle |
| resp_byte | output | 8 | Answer byte, AAh or FFh |
| aa_flag | output | 1 | Authorization-accepted flag |
| en_lfs | output | 1 | Refresh-permission flag |
| target_addr | output | 16 | Target address register |

## Verification
The hardest case to reach is the MAC-free data rewrite. It needs a refresh to a data address below 0080h, then only commands that keep the permission, then an exact three-byte pattern that carries the current AA and partial flags, with every protection input clear. Random stimulus seldom produces that sequence by chance. The stimulus therefore favours refresh addresses below 0080h and read-scratchpad commands, and it sends the correct pattern most of the time. Directed cases cover page-0 protection, bus reset partway through the authorization bytes, and addresses above the register page.

// File: rtl/lfsg_pkg.sv
package lfsg_pkg;
  localparam int ADDR_W = 16;

  localparam logic [7:0] CMD_WRITE_SP = 8'h0F;
  localparam logic [7:0] CMD_READ_SP  = 8'hAA;
  localparam logic [7:0] CMD_LOAD_SEC = 8'h5A;
  localparam logic [7:0] CMD_REFRESH  = 8'hA3;
  localparam logic [7:0] CMD_READ_MEM = 8'hF0;

  localparam logic [ADDR_W-1:0] SECRET_BASE = 16'h0080;
  localparam logic [ADDR_W-1:0] ADDR_LIMIT  = 16'h0090;
  localparam logic [ADDR_W-1:0] PAGE1_BASE  = 16'h0020;

  localparam logic [7:0] RESP_OK   = 8'hAA;
  localparam logic [7:0] RESP_FAIL = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_AUTH0, ST_AUTH1, ST_AUTH2, ST_BUSY
  } gate_state_e;

  // Status byte: bit7 AA, bit6 one, bit5 partial flag, bits 4..0 ones.
  function automatic logic [7:0] status_byte(input logic aa, input logic pf);
    return {aa, 1'b1, pf, 5'b11111};
  endfunction

  function automatic logic [7:0] auth_expect(input logic [ADDR_W-1:0] ta,
                                             input logic aa, input logic pf,
                                             input logic [1:0] idx);
    logic [7:0] b;
    case (idx)
      2'd0:    b = {ta[7:3], 3'b000};
      2'd1:    b = ta[15:8];
      default: b = status_byte(aa, pf);
    endcase
    return b;
  endfunction

  function automatic logic cmd_keeps_lfs(input logic [7:0] code);
    return (code == CMD_READ_SP) || (code == CMD_READ_MEM) || (code == CMD_LOAD_SEC);
  endfunction

  function automatic logic copy_allowed(input logic en, input logic [ADDR_W-1:0] ta,
                                        input logic sec_wp, input logic mem_wp,
                                        input logic pg0_wp);
    logic ok;
    if (!en) ok = (ta == SECRET_BASE) && !sec_wp;
    else     ok = (ta < SECRET_BASE) && !mem_wp && !(pg0_wp && (ta < PAGE1_BASE));
    return ok;
  endfunction
endpackage

// File: rtl/lfsg_state_track.sv
module lfsg_state_track
  import lfsg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_stb,
  input  logic [7:0]        cmd_byte,
  input  logic              addr_stb,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              set_aa,
  output logic [ADDR_W-1:0] ta_q,
  output logic              aa_q,
  output logic              en_q
);
  logic [7:0] last_cmd;
  logic       addr_cmd;
  logic       addr_take;

  assign addr_cmd  = (last_cmd == CMD_WRITE_SP) || (last_cmd == CMD_REFRESH);
  assign addr_take = addr_stb && addr_cmd && (addr_in < ADDR_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_cmd <= 8'h00;
      ta_q     <= '0;
      aa_q     <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      if (cmd_stb) begin
        last_cmd <= cmd_byte;
        if (!cmd_keeps_lfs(cmd_byte)) en_q <= 1'b0;
      end
      if (addr_take) begin
        ta_q <= {addr_in[ADDR_W-1:3], 3'b000};
        aa_q <= 1'b0;
        en_q <= (last_cmd == CMD_REFRESH) && (addr_in < SECRET_BASE);
      end
      if (set_aa) aa_q <= 1'b1;
    end
  end
endmodule

// File: rtl/lfsg_auth_match.sv
module lfsg_auth_match (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       auth_stb,
  input  logic [7:0] auth_byte,
  input  logic [7:0] exp_byte,
  output logic       all_ok
);
  logic miss_q;
  logic byte_ok;

  assign byte_ok = (auth_byte == exp_byte);
  assign all_ok  = !miss_q && byte_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        miss_q <= 1'b0;
    else if (start)    miss_q <= 1'b0;
    else if (auth_stb && !byte_ok) miss_q <= 1'b1;
  end
endmodule

// File: rtl/lfsg_prog_timer.sv
module lfsg_prog_timer #(
  parameter int PROG_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  logic [CNT_W-1:0] cnt;

  assign expired = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= CNT_W'(PROG_CYCLES - 1);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/lfs_copy_gate.sv
module lfs_copy_gate
  import lfsg_pkg::*;
#(
  parameter int PROG_CYCLES = 5000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_reset,
  input  logic        cmd_stb,
  input  logic [7:0]  cmd_byte,
  input  logic        addr_stb,
  input  logic [15:0] addr_in,
  input  logic        auth_stb,
  input  logic [7:0]  auth_byte,
  input  logic        pf_flag,
  input  logic        secret_wp,
  input  logic        mem_wp,
  input  logic        page0_wp,
  output logic        copy_start,
  output logic        copy_to_secret,
  output logic        busy,
  output logic        resp_stb,
  output logic [7:0]  resp_byte,
  output logic        aa_flag,
  output logic        en_lfs,
  output logic [15:0] target_addr
);
  gate_state_e state;
  logic        idle;
  logic        in_auth;
  logic        lfs_begin;
  logic        last_auth;
  logic        accept_evt;
  logic        reject_evt;
  logic        pattern_ok;
  logic        permit;
  logic        timer_done;
  logic [1:0]  auth_idx;
  logic [7:0]  exp_byte;

  assign idle      = (state == ST_IDLE);
  assign in_auth   = (state == ST_AUTH0) || (state == ST_AUTH1) || (state == ST_AUTH2);
  assign lfs_begin = idle && cmd_stb && (cmd_byte == CMD_LOAD_SEC);
  assign auth_idx  = (state == ST_AUTH0) ? 2'd0 : (state == ST_AUTH1) ? 2'd1 : 2'd2;
  assign exp_byte  = auth_expect(target_addr, aa_flag, pf_flag, auth_idx);
  assign permit    = copy_allowed(en_lfs, target_addr, secret_wp, mem_wp, page0_wp);
  assign last_auth = (state == ST_AUTH2) && auth_stb && !bus_reset;
  assign accept_evt = last_auth && pattern_ok && permit;
  assign reject_evt = last_auth && !(pattern_ok && permit);
  assign busy      = (state == ST_BUSY);

  lfsg_state_track u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_stb  (cmd_stb && idle),
    .cmd_byte (cmd_byte),
    .addr_stb (addr_stb && idle),
    .addr_in  (addr_in),
    .set_aa   (accept_evt),
    .ta_q     (target_addr),
    .aa_q     (aa_flag),
    .en_q     (en_lfs)
  );

  lfsg_auth_match u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (lfs_begin),
    .auth_stb  (auth_stb && in_auth),
    .auth_byte (auth_byte),
    .exp_byte  (exp_byte),
    .all_ok    (pattern_ok)
  );

  lfsg_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept_evt),
    .expired (timer_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      copy_start     <= 1'b0;
      copy_to_secret <= 1'b0;
      resp_stb       <= 1'b0;
      resp_byte      <= RESP_FAIL;
    end else begin
      copy_start <= 1'b0;
      resp_stb   <= 1'b0;
      case (state)
        ST_IDLE: if (lfs_begin) state <= ST_AUTH0;
        ST_AUTH0, ST_AUTH1: begin
          if (bus_reset)     state <= ST_IDLE;
          else if (auth_stb) state <= (state == ST_AUTH0) ? ST_AUTH1 : ST_AUTH2;
        end
        ST_AUTH2: begin
          if (bus_reset) state <= ST_IDLE;
          else if (accept_evt) begin
            state          <= ST_BUSY;
            copy_start     <= 1'b1;
            copy_to_secret <= !en_lfs;
          end else if (reject_evt) begin
            state     <= ST_IDLE;
            resp_stb  <= 1'b1;
            resp_byte <= RESP_FAIL;
          end
        end
        ST_BUSY: if (timer_done) begin
          state     <= ST_IDLE;
          resp_stb  <= 1'b1;
          resp_byte <= RESP_OK;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lfsg_gate_checks.sv
module lfsg_gate_checks #(
  parameter int PROG_CYCLES = 5000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_reset,
  input logic        cmd_stb,
  input logic [7:0]  cmd_byte,
  input logic        addr_stb,
  input logic [15:0] addr_in,
  input logic        secret_wp,
  input logic        mem_wp,
  input logic        copy_start,
  input logic        copy_to_secret,
  input logic        busy,
  input logic        resp_stb,
  input logic [7:0]  resp_byte,
  input logic        aa_flag,
  input logic        en_lfs,
  input logic [15:0] target_addr,
  input logic        accept_evt
);
  localparam int BW = $clog2(PROG_CYCLES + 2);
  logic [BW-1:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  a_r2_secret_target: assert property (@(posedge clk) disable iff (!rst_n)
    copy_start && copy_to_secret |-> target_addr == 16'h0080 && !$past(secret_wp));

  a_r3_data_target: assert property (@(posedge clk) disable iff (!rst_n)
    copy_start && !copy_to_secret |-> en_lfs && target_addr < 16'h0080 && !$past(mem_wp));

  a_r7_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> copy_start && busy && aa_flag);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    copy_start |=> !copy_start);

  a_r7_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == BW'(PROG_CYCLES));

  a_r7_ok_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    resp_stb && resp_byte == 8'hAA |-> $past(busy) && !busy);

  a_r8_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    resp_stb && resp_byte == 8'hFF |-> !busy && !copy_start);

  a_r8_resp_codes: assert property (@(posedge clk) disable iff (!rst_n)
    resp_stb |-> resp_byte == 8'hAA || resp_byte == 8'hFF);

  a_r4_en_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_lfs) |-> $past(addr_stb) && $past(addr_in) < 16'h0080);

  a_r5_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb && cmd_byte == 8'hAA && !addr_stb |=> $stable(en_lfs));

  a_r9_reset_holds: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset && !busy && !cmd_stb && !addr_stb |=> $stable(aa_flag) && $stable(en_lfs));
endmodule

bind lfs_copy_gate lfsg_gate_checks #(.PROG_CYCLES(PROG_CYCLES)) u_gate_checks (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_reset      (bus_reset),
  .cmd_stb        (cmd_stb),
  .cmd_byte       (cmd_byte),
  .addr_stb       (addr_stb),
  .addr_in        (addr_in),
  .secret_wp      (secret_wp),
  .mem_wp         (mem_wp),
  .copy_start     (copy_start),
  .copy_to_secret (copy_to_secret),
  .busy           (busy),
  .resp_stb       (resp_stb),
  .resp_byte      (resp_byte),
  .aa_flag        (aa_flag),
  .en_lfs         (en_lfs),
  .target_addr    (target_addr),
  .accept_evt     (accept_evt)
);

// File: tb/test_lfs_copy_gate.sv
module test_lfs_copy_gate;
  localparam int PROG = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_reset = 1'b0;
  logic        cmd_stb = 1'b0;
  logic [7:0]  cmd_byte = 8'h00;
  logic        addr_stb = 1'b0;
  logic [15:0] addr_in = 16'h0000;
  logic        auth_stb = 1'b0;
  logic [7:0]  auth_byte = 8'h00;
  logic        pf_flag = 1'b0;
  logic        secret_wp = 1'b0;
  logic        mem_wp = 1'b0;
  logic        page0_wp = 1'b0;
  logic        copy_start, copy_to_secret, busy, resp_stb, aa_flag, en_lfs;
  logic [7:0]  resp_byte;
  logic [15:0] target_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [15:0] m_ta = 16'h0000;
  logic        m_aa = 1'b0;
  logic        m_en = 1'b0;
  logic [7:0]  m_last = 8'h00;

  always #5 clk = ~clk;

  lfs_copy_gate #(.PROG_CYCLES(PROG)) i_lfs_copy_gate (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .cmd_stb(cmd_stb), .cmd_byte(cmd_byte), .addr_stb(addr_stb), .addr_in(addr_in),
    .auth_stb(auth_stb), .auth_byte(auth_byte), .pf_flag(pf_flag),
    .secret_wp(secret_wp), .mem_wp(mem_wp), .page0_wp(page0_wp),
    .copy_start(copy_start), .copy_to_secret(copy_to_secret), .busy(busy),
    .resp_stb(resp_stb), .resp_byte(resp_byte), .aa_flag(aa_flag),
    .en_lfs(en_lfs), .target_addr(target_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic keeps(input logic [7:0] c);
    return c inside {8'hAA, 8'hF0, 8'h5A};
  endfunction

  function automatic logic [7:0] pattern(input int i);
    if (i == 0) return m_ta[7:0] & 8'hF8;
    if (i == 1) return m_ta[15:8];
    return {m_aa, 1'b1, pf_flag, 5'h1F};
  endfunction

  function automatic logic permitted();
    if (m_en) return (m_ta < 16'h0080) && !mem_wp && !(page0_wp && m_ta < 16'h0020);
    return (m_ta == 16'h0080) && !secret_wp;
  endfunction

  task automatic send_cmd(input logic [7:0] c);
    @(negedge clk); cmd_byte = c; cmd_stb = 1'b1;
    @(negedge clk); cmd_stb = 1'b0;
    m_last = c;
    if (!keeps(c)) m_en = 1'b0;
    chk("R5 en_lfs after command", en_lfs, m_en);
  endtask

  task automatic send_addr(input logic [15:0] a);
    @(negedge clk); addr_in = a; addr_stb = 1'b1;
    @(negedge clk); addr_stb = 1'b0;
    if ((m_last == 8'h0F || m_last == 8'hA3) && a < 16'h0090) begin
      m_ta = a & 16'hFFF8;
      m_aa = 1'b0;
      m_en = (m_last == 8'hA3) && (a < 16'h0080);
    end
    chk("R6 target_addr", target_addr, m_ta);
    chk("R6 aa_flag after address", aa_flag, m_aa);
    chk("R4 en_lfs after address", en_lfs, m_en);
  endtask

  task automatic send_auth(input logic [7:0] b);
    @(negedge clk); auth_byte = b; auth_stb = 1'b1;
    @(negedge clk); auth_stb = 1'b0;
  endtask

  // bad_idx / rst_idx: -1 for none
  task automatic do_lfs(input int bad_idx, input int rst_idx);
    logic ok;
    send_cmd(8'h5A);
    for (int i = 0; i < 3; i++) begin
      if (i == rst_idx) begin
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
        chk("R9 aa_flag held by bus reset", aa_flag, m_aa);
        chk("R9 en_lfs held by bus reset", en_lfs, m_en);
        send_auth(pattern(2));
        chk("R9 stray byte gives no answer", resp_stb, 1'b0);
        chk("R9 stray byte gives no copy", {copy_start, busy}, 2'b00);
        return;
      end
      send_auth(i == bad_idx ? pattern(i) ^ (8'h01 << ($urandom % 8)) : pattern(i));
    end
    ok = (bad_idx < 0) && permitted();
    if (!ok) begin
      chk("R8 reject answer strobe", resp_stb, 1'b1);
      chk("R1 reject answer FFh", resp_byte, 8'hFF);
      chk("R8 no copy on reject", {copy_start, busy}, 2'b00);
    end else begin
      m_aa = 1'b1;
      chk("R7 copy_start on accept", copy_start, 1'b1);
      chk("R7 busy on accept", busy, 1'b1);
      chk(m_en ? "R3 destination data" : "R2 destination secret", copy_to_secret, !m_en);
      chk("R2 aa_flag set by copy", aa_flag, 1'b1);
      for (int k = 1; k < PROG; k++) begin
        @(negedge clk);
        chk("R7 busy held", {busy, copy_start, resp_stb}, 3'b100);
      end
      @(negedge clk);
      chk("R7 busy ends", busy, 1'b0);
      chk("R7 success answer", {resp_stb, resp_byte}, {1'b1, 8'hAA});
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1961_5A5A));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset flags", {aa_flag, en_lfs, busy, copy_start, resp_stb}, 5'b0);
    chk("R10 reset target", target_addr, 16'h0000);

    // secret load and repeat with AA already set
    send_cmd(8'h0F); send_addr(16'h0085);
    send_cmd(8'hAA);
    do_lfs(-1, -1);
    do_lfs(-1, -1);
    // protected secret
    secret_wp = 1'b1;
    send_cmd(8'h0F); send_addr(16'h0080);
    do_lfs(-1, -1);
    secret_wp = 1'b0;
    // data rewrite after refresh
    send_cmd(8'hA3); send_addr(16'h0043);
    send_cmd(8'hAA);
    do_lfs(-1, -1);
    // refresh at register page: no permission
    send_cmd(8'hA3); send_addr(16'h0088);
    do_lfs(-1, -1);
    // disturbing command revokes permission
    send_cmd(8'hA3); send_addr(16'h0010);
    send_cmd(8'h55);
    do_lfs(-1, -1);
    // page 0 protection
    page0_wp = 1'b1;
    send_cmd(8'hA3); send_addr(16'h0017);
    do_lfs(-1, -1);
    page0_wp = 1'b0;
    // address beyond the register page ignored
    send_cmd(8'h0F); send_addr(16'h0093);
    // corrupt pattern and aborted command
    send_cmd(8'h0F); send_addr(16'h0080);
    do_lfs(1, -1);
    send_cmd(8'hA3); send_addr(16'h0060);
    do_lfs(-1, 1);
    do_lfs(-1, -1);

    for (int it = 0; it < 400; it++) begin
      int op;
      @(negedge clk);
      pf_flag   = ($urandom % 4) == 0;
      secret_wp = ($urandom % 5) == 0;
      mem_wp    = ($urandom % 6) == 0;
      page0_wp  = ($urandom % 3) == 0;
      op = $urandom % 10;
      if (op < 3) begin
        send_cmd(8'hA3);
        send_addr(($urandom % 4 == 0) ? 16'(16'h0078 + $urandom % 32) : 16'($urandom % 128));
      end else if (op < 5) begin
        send_cmd(8'h0F);
        send_addr(($urandom % 2 == 0) ? 16'(16'h0080 + $urandom % 8) : 16'($urandom % 160));
      end else if (op < 6) begin
        logic [7:0] others [5] = '{8'hAA, 8'hF0, 8'h55, 8'h33, 8'hA5};
        send_cmd(others[$urandom % 5]);
      end else begin
        int r = $urandom % 10;
        do_lfs(r == 0 ? int'($urandom % 3) : -1, r == 1 ? int'($urandom % 3) : -1);
      end
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule